// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator with Gate-State Interlock

This block turns one PWM stream into the two gate enables of a half-bridge leg: an active-low enable for the top switch and an active-high enable for the bottom switch. Every PWM transition first drops both enables, then waits out a dead interval that is given in nanoseconds and converted to clock cycles at elaboration. Only then does it enable the side that the new PWM level asks for. A PWM level of 1 requests the top switch and a level of 0 requests the bottom switch.

A fixed delay is not trusted on its own. Each switch returns a feedback bit (1 means its gate is still on). Both bits pass through two-flop synchronizers, and a side is granted only when the synchronized feedback of the opposite switch reads off. The same off-flag also gates the enable continuously, so an opposite gate that reads on forces the enable low at any time. If the opposite feedback stays on past a timeout once the dead interval has run out, the block latches a fault and holds both switches off until reset. A full bridge uses two instances.

Top module: `deadband_gate_ctrl`

## Requirements
- R1: The top enable (`hi_gate_n` = 0) and the bottom enable (`lo_gate` = 1) are never active in the same cycle.
- R2: The top enable is active low. After synchronous reset `hi_gate_n` = 1, `lo_gate` = 0 and `fault` = 0, and both enables stay inactive, whatever the steady PWM level, until the first PWM change.
- R3: In the cycle after any PWM change is sampled, both enables are inactive.
- R4: With DEAD_CYC = ceil(DEAD_NS*1000/CLK_PERIOD_PS), at least 1, and the opposite feedback already off, the requested enable becomes active exactly DEAD_CYC clock edges after the edge at which both enables dropped.
- R5: Each feedback bit passes through two flops. A side is granted only once the synchronized opposite feedback reads off. A release of the feedback between edges j and j+1 therefore lets the enable become active at edge j+3, provided the dead interval has expired.
- R6: While the synchronized opposite feedback reads on, an enable already granted is forced inactive. It returns once that feedback reads off again.
- R7: A PWM pulse shorter than DEAD_CYC cycles produces no active enable for the level of that pulse.
- R8: If, after the dead interval, the opposite feedback still reads on for TIMEOUT_CYC consecutive evaluation cycles, `fault` becomes 1 and both enables are inactive.
- R9: Once set, `fault` and the all-off state persist through any PWM activity and feedback change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM command: 1 requests top switch, 0 requests bottom switch |
| hi_fb | input | 1 | Top switch gate-state feedback, 1 = still on (asynchronous) |
| lo_fb | input | 1 | Bottom switch gate-state feedback, 1 = still on (asynchronous) |
| hi_gate_n | output | 1 | Top switch enable, active low |
| lo_gate | output | 1 | Bottom switch enable, active high |
| fault | output | 1 | Sticky feedback-timeout fault |

## Verification
Two mechanisms can act in the same cycle: expiry of the dead counter and the feedback confirmation. The bench provokes their overlap by holding the opposite feedback on past the end of the dead interval and then releasing it. The enable must follow the synchronizer lag, not the counter. The same hold, kept long enough, makes the timeout compete with a late grant. The bench judges the exact edge at which either the enable or the fault appears against the cycle counts in R4, R5 and R8.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [2:0] {
        PH_WAIT    = 3'd0,
        PH_DEAD    = 3'd1,
        PH_CONFIRM = 3'd2,
        PH_ON      = 3'd3,
        PH_FAULT   = 3'd4
    } phase_e;

endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/dbg_interlock.sv
module dbg_interlock (
    input  logic req_hi,
    input  logic req_lo,
    input  logic hi_off,
    input  logic lo_off,
    output logic hi_ok,
    output logic lo_ok
);

    logic block_hi;
    logic block_lo;

    // NAND of (opposite confirmed off, opposite not requested) gives a block term;
    // NOR of block term and inverted request yields the permitted enable.
    always_comb begin
        block_hi = ~(lo_off & ~req_lo);
        block_lo = ~(hi_off & ~req_hi);
        hi_ok    = ~(block_hi | ~req_hi);
        lo_ok    = ~(block_lo | ~req_lo);
    end

endmodule

// File: rtl/deadband_gate_ctrl.sv
module deadband_gate_ctrl #(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int DEAD_NS       = 20,
    parameter int TIMEOUT_CYC   = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic hi_fb,
    input  logic lo_fb,
    output logic hi_gate_n,
    output logic lo_gate,
    output logic fault
);
    import dbg_pkg::*;

    localparam int DEAD_RAW = (DEAD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
    localparam int TO_CYC   = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
    localparam int CW       = $clog2(DEAD_CYC + 1);
    localparam int TW       = $clog2(TO_CYC + 1);
    localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYC - 1);
    localparam logic [TW-1:0] TO_LAST   = TW'(TO_CYC - 1);

    typedef struct packed {
        phase_e          phase;
        logic            pwm;
        logic            side_hi;
        logic [CW-1:0]   cnt;
        logic [TW-1:0]   wcnt;
        logic            hi_en;
        logic            lo_en;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [1:0] fb_sync;
    logic       hi_off;
    logic       lo_off;
    logic       opp_off;
    logic       pwm_edge;
    logic       req_hi;
    logic       req_lo;
    logic       hi_ok;
    logic       lo_ok;

    dbg_sync2 #(.W(2)) u_fb_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({hi_fb, lo_fb}),
        .sync_o  (fb_sync)
    );

    assign hi_off = ~fb_sync[1];
    assign lo_off = ~fb_sync[0];

    always_comb begin
        st_d     = st_q;
        st_d.pwm = pwm_in;
        pwm_edge = (pwm_in != st_q.pwm);
        opp_off  = st_q.side_hi ? lo_off : hi_off;

        if (st_q.phase == PH_FAULT) begin
            st_d.phase = PH_FAULT;
        end else if (pwm_edge) begin
            st_d.phase   = PH_DEAD;
            st_d.side_hi = pwm_in;
            st_d.cnt     = DEAD_LOAD;
            st_d.wcnt    = '0;
        end else begin
            unique case (st_q.phase)
                PH_DEAD: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end else if (opp_off) begin
                        st_d.phase = PH_ON;
                    end else if (st_q.wcnt == TO_LAST) begin
                        st_d.phase = PH_FAULT;
                    end else begin
                        st_d.phase = PH_CONFIRM;
                        st_d.wcnt  = st_q.wcnt + 1'b1;
                    end
                end
                PH_CONFIRM: begin
                    if (opp_off) begin
                        st_d.phase = PH_ON;
                    end else if (st_q.wcnt == TO_LAST) begin
                        st_d.phase = PH_FAULT;
                    end else begin
                        st_d.wcnt = st_q.wcnt + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = st_q.phase;
                end
            endcase
        end

        req_hi = (st_d.phase == PH_ON) &&  st_d.side_hi;
        req_lo = (st_d.phase == PH_ON) && !st_d.side_hi;
    end

    dbg_interlock u_interlock (
        .req_hi (req_hi),
        .req_lo (req_lo),
        .hi_off (hi_off),
        .lo_off (lo_off),
        .hi_ok  (hi_ok),
        .lo_ok  (lo_ok)
    );

    ctl_t st_n;
    always_comb begin
        st_n       = st_d;
        st_n.hi_en = hi_ok;
        st_n.lo_en = lo_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.phase   <= PH_WAIT;
            st_q.pwm     <= pwm_in;
        end else begin
            st_q <= st_n;
        end
    end

    assign hi_gate_n = ~st_q.hi_en;
    assign lo_gate   = st_q.lo_en;
    assign fault     = (st_q.phase == PH_FAULT);

endmodule

// File: rtl/deadband_gate_ctrl_checker.sv
module deadband_gate_ctrl_checker (
    input logic clk,
    input logic rst,
    input logic pwm_in,
    input logic hi_gate_n,
    input logic lo_gate,
    input logic fault,
    input logic hi_off,
    input logic lo_off
);

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        !(!hi_gate_n && lo_gate));

    assert_edge_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (pwm_in != $past(pwm_in)) |=> (hi_gate_n && !lo_gate));

    assert_hi_confirm_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_gate_n) |-> $past(lo_off));

    assert_lo_confirm_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_gate) |-> $past(hi_off));

    assert_hi_forced_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(lo_off) |-> hi_gate_n);

    assert_lo_forced_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(hi_off) |-> !lo_gate);

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (hi_gate_n && !lo_gate));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

endmodule

bind deadband_gate_ctrl deadband_gate_ctrl_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .pwm_in    (pwm_in),
    .hi_gate_n (hi_gate_n),
    .lo_gate   (lo_gate),
    .fault     (fault),
    .hi_off    (hi_off),
    .lo_off    (lo_off)
);

// File: tb/deadband_gate_ctrl_bench.sv
module deadband_gate_ctrl_bench;

    localparam int CLK_PS  = 10000;
    localparam int DEAD_NS = 60;
    localparam int TO_CYC  = 8;
    localparam int DEAD_CYC = (DEAD_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0;
    logic force_hi = 1'b0;
    logic force_lo = 1'b0;
    logic hi_gate_n;
    logic lo_gate;
    logic fault;
    logic hi_fb;
    logic lo_fb;

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Gate feedback modelled as a copy of the drive, optionally held on.
    assign hi_fb = force_hi | ~hi_gate_n;
    assign lo_fb = force_lo | lo_gate;

    deadband_gate_ctrl #(
        .CLK_PERIOD_PS (CLK_PS),
        .DEAD_NS       (DEAD_NS),
        .TIMEOUT_CYC   (TO_CYC)
    ) u_deadband_gate_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pwm_in    (pwm_in),
        .hi_fb     (hi_fb),
        .lo_fb     (lo_fb),
        .hi_gate_n (hi_gate_n),
        .lo_gate   (lo_gate),
        .fault     (fault)
    );

    // R1 continuous monitor
    always @(negedge clk) begin
        if (!rst) begin
            mon_checks++;
            if (!hi_gate_n && lo_gate) begin
                mon_fails++;
                $display("FAIL R1: hi_gate_n=%0b lo_gate=%0b expected not both active", hi_gate_n, lo_gate);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: {hi_gate_n,lo_gate,fault} actual=%03b expected=%03b", tag, act, exp);
        end
    endtask

    task automatic expect_outs(input string tag, input logic hn, input logic lg, input logic fl);
        chk({hi_gate_n, lo_gate, fault} === {hn, lg, fl}, tag, {hi_gate_n, lo_gate, fault}, {hn, lg, fl});
    endtask

    // Change PWM and follow the R3/R4 timing to the granted side.
    task automatic switch_to(input logic lvl, input string tag);
        pwm_in = lvl;
        tick();
        expect_outs({tag, " R3 blank"}, 1'b1, 1'b0, 1'b0);
        repeat (DEAD_CYC - 1) tick();
        expect_outs({tag, " R4 still dead"}, 1'b1, 1'b0, 1'b0);
        tick();
        if (lvl) expect_outs({tag, " R4 top on"}, 1'b0, 1'b0, 1'b0);
        else     expect_outs({tag, " R4 bottom on"}, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pwm_in = 1'b1;
        repeat (3) tick();
        expect_outs("R2 in reset", 1'b1, 1'b0, 1'b0);
        rst = 1'b0;
        repeat (10) tick();
        expect_outs("R2 wait first edge", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_basic();
        switch_to(1'b0, "basic fall");
        repeat (4) tick();
        expect_outs("R4 bottom held", 1'b1, 1'b1, 1'b0);
        switch_to(1'b1, "basic rise");
    endtask

    task automatic t_interlock();
        force_lo = 1'b1;          // after edge j
        tick();                   // j+1
        tick();                   // j+2
        expect_outs("R6 before sync lag", 1'b0, 1'b0, 1'b0);
        tick();                   // j+3
        expect_outs("R6 forced off", 1'b1, 1'b0, 1'b0);
        force_lo = 1'b0;
        tick();
        tick();                   // j+5
        expect_outs("R6 still blocked", 1'b1, 1'b0, 1'b0);
        tick();                   // j+6
        expect_outs("R6 restored", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fb_wait();
        switch_to(1'b0, "prep bottom");
        force_lo = 1'b1;
        pwm_in = 1'b1;
        tick();                   // edge k
        expect_outs("R5 blank", 1'b1, 1'b0, 1'b0);
        repeat (8) tick();        // k+8
        expect_outs("R5 held past dead", 1'b1, 1'b0, 1'b0);
        force_lo = 1'b0;
        tick();
        tick();                   // k+10
        expect_outs("R5 sync lag", 1'b1, 1'b0, 1'b0);
        tick();                   // k+11
        expect_outs("R5 granted after confirm", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_short();
        bit saw_hi;
        switch_to(1'b0, "prep bottom 2");
        saw_hi = 1'b0;
        pwm_in = 1'b1;
        repeat (DEAD_CYC - 3) begin
            tick();
            if (!hi_gate_n) saw_hi = 1'b1;
        end
        pwm_in = 1'b0;
        repeat (2 * DEAD_CYC + 4) begin
            tick();
            if (!hi_gate_n) saw_hi = 1'b1;
        end
        chk(!saw_hi, "R7 short pulse", {saw_hi, 2'b00}, 3'b000);
        expect_outs("R7 bottom after short", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_fault();
        force_lo = 1'b1;
        pwm_in = 1'b1;
        tick();                   // edge k
        repeat (12) tick();       // k+12
        expect_outs("R8 not yet", 1'b1, 1'b0, 1'b0);
        tick();                   // k+13
        expect_outs("R8 fault set", 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            pwm_in = ~pwm_in;
            repeat (DEAD_CYC + 2) tick();
        end
        force_lo = 1'b0;
        pwm_in = 1'b0;
        repeat (DEAD_CYC + 6) tick();
        expect_outs("R9 fault sticky", 1'b1, 1'b0, 1'b1);
        pwm_in = 1'b1;
        repeat (DEAD_CYC + 6) tick();
        expect_outs("R9 pwm ignored", 1'b1, 1'b0, 1'b1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        expect_outs("R9 cleared by reset", 1'b1, 1'b0, 1'b0);
        switch_to(1'b0, "after fault");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_interlock();
        t_fb_wait();
        t_short();
        t_fault();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + mon_checks, fails + mon_fails);
            $finish;
        end
    end

endmodule